// File: doc/BRIEF.md
# Multislope ADC Integration Sequencer

This block sequences one conversion of a multislope integrating converter. It steers two reference switches through a 2-bit select. It raises a measure-enable line while the input is being integrated. It watches a comparator on the integrator output. A command carries the number of run-up cycles. For each command the block does the following, in order:

1. Asks an external auxiliary converter for a first residue reading.
2. Runs fixed-length run-up cycles whose polarity follows the comparator.
3. Reports how many cycles chose the first polarity.
4. Runs a counted rundown towards the threshold.
5. Reports both rundown counts.
6. Asks for a second residue reading.

When no command is pending, the block dithers the integrator around the comparator threshold. Results leave on a valid/ready stream. A 2-bit kind field tags each result word.

Top module: `msadc_seq`

## Requirements
- R1: During and directly after reset the block is idle: `sw_sel` = 01, `integ_en` = 0, `aux_req` = 0, `rs_valid` = 0, `cmd_ready` = 1.
- R2: A command is taken in a clock where `cmd_ready` and `cmd_valid` are both high. In the next clock `sw_sel` = 00 and `aux_req` is high for exactly one clock. The block then holds `sw_sel` = 00 until it samples `aux_done` high. Outside the two wait phases, `aux_done` has no effect.
- R3: `integ_en` is high for exactly N × CYC_CLKS consecutive clocks per command, where N is the command's cycle count, and is low at all other times.
- R4: In every run-up cycle the first clock selects 01. If the synchronized comparator sampled in that clock was 0, the remaining CYC_CLKS−1 clocks select 10; otherwise they stay at 01.
- R5: The first result word has kind 0. Its value is all ones minus the number of run-up cycles whose first-clock comparator sample was 1. With N = 0, run-up is skipped and the word is all ones.
- R6: Rundown picks 01 if the synchronized comparator is 1 when rundown starts, and 10 otherwise. Each clock without a change adds one to that polarity's counter. The rundown ends in the first clock whose comparator sample differs from the starting level.
- R7: After rundown, `sw_sel` = 00. The words of kind 1 (polarity-01 count) and kind 2 (polarity-10 count) follow in that order. Then a second one-clock `aux_req` is issued, and the block returns to idle on `aux_done`.
- R8: While `rs_valid` is high and `rs_ready` is low, the next clock keeps `rs_valid`, `rs_data` and `rs_kind` unchanged.
- R9: In idle, `sw_sel` = 01. A synchronized comparator sample of 0 with no command present selects 10 for exactly two clocks, with `cmd_ready` low, and then returns to idle. A command present in the same clock wins over the dither step.
- R10: `cmp_async` passes through SYNC_STAGES flops before any decision uses it. With the default of 2, a fall of the input in idle shows up as `sw_sel` = 10 in the third clock after the change.
- R11: `sw_sel` never carries the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_cycles | input | CNT_W | Number of run-up cycles for this command |
| cmp_async | input | 1 | Comparator on the integrator, asynchronous |
| sw_sel | output | 2 | Reference select: 00 off, 01 polarity one, 10 polarity two |
| integ_en | output | 1 | High during run-up integration |
| aux_req | output | 1 | One-clock residue conversion request |
| aux_done | input | 1 | Residue conversion complete |
| rs_valid | output | 1 | Result word valid |
| rs_ready | input | 1 | Result word accepted |
| rs_data | output | CNT_W | Result value |
| rs_kind | output | 2 | 0 high-cycle count, 1 rundown polarity-01 count, 2 rundown polarity-10 count |

## Verification
In idle, two things can land in the same clock: a new command and a dither step on a low comparator sample. Only one of them may take effect. The bench holds the comparator low so that the block alternates between probe and push clocks. It then raises `cmd_valid` in the middle of that pattern. A reference model kept in the bench predicts, clock by clock, whether the command is taken (switches off next clock) or must wait out the two push clocks. Every output is compared against that prediction. A second overlap, a spurious `aux_done` arriving outside a wait phase, is judged the same way.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH,
    ST_REQ1,
    ST_WAIT1,
    ST_RUN,
    ST_EMIT_HI,
    ST_RD_ARM,
    ST_RD_RUN,
    ST_EMIT_P1,
    ST_EMIT_P2,
    ST_REQ2,
    ST_WAIT2
  } seq_state_e;

  localparam logic [1:0] SW_OFF = 2'b00;
  localparam logic [1:0] SW_P1  = 2'b01;
  localparam logic [1:0] SW_P2  = 2'b10;

  localparam logic [1:0] KIND_HI = 2'd0;
  localparam logic [1:0] KIND_P1 = 2'd1;
  localparam logic [1:0] KIND_P2 = 2'd2;

  localparam int PUSH_CLKS = 2;

  // first clock of a run-up cycle always probes with polarity one
  function automatic logic [1:0] runup_sel(input logic first_clk, input logic keep_p1);
    return (first_clk || keep_p1) ? SW_P1 : SW_P2;
  endfunction

  // comparator high at rundown start means polarity one pulls towards threshold
  function automatic logic [1:0] rundown_sel(input logic start_high);
    return start_high ? SW_P1 : SW_P2;
  endfunction

endpackage

// File: rtl/msadc_sync.sv
module msadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/msadc_ru_timer.sv
module msadc_ru_timer #(
  parameter int CNT_W    = 16,
  parameter int CYC_CLKS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             advance,
  output logic             first_clk,
  output logic             cyc_end,
  output logic             last_cyc,
  output logic             empty
);

  localparam int PH_W = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      ph_q   <= '0;
      left_q <= load_val;
    end else if (advance) begin
      if (ph_q == PH_LAST) begin
        ph_q   <= '0;
        left_q <= left_q - ONE;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign first_clk = (ph_q == '0);
  assign cyc_end   = (ph_q == PH_LAST);
  assign last_cyc  = cyc_end && (left_q == ONE);
  assign empty     = (left_q == '0);

endmodule

// File: rtl/msadc_rd_ctr.sv
module msadc_rd_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_p1,
  input  logic             inc_p2,
  output logic [CNT_W-1:0] p1_cnt,
  output logic [CNT_W-1:0] p2_cnt
);

  logic [1:0]            inc_vec;
  logic [1:0][CNT_W-1:0] cnt_q;

  assign inc_vec = {inc_p2, inc_p1};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q[d] <= '0;
      else if (clr)        cnt_q[d] <= '0;
      else if (inc_vec[d]) cnt_q[d] <= cnt_q[d] + 1'b1;
    end
  end

  assign p1_cnt = cnt_q[0];
  assign p2_cnt = cnt_q[1];

endmodule

// File: rtl/msadc_seq.sv
module msadc_seq
  import msadc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int CYC_CLKS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CNT_W-1:0] cmd_cycles,
  input  logic             cmp_async,
  output logic [1:0]       sw_sel,
  output logic             integ_en,
  output logic             aux_req,
  input  logic             aux_done,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [CNT_W-1:0] rs_data,
  output logic [1:0]       rs_kind
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  seq_state_e       st_q, st_d;
  logic             cmp_sync;
  logic             first_clk, cyc_end, last_cyc, ru_empty;
  logic             push_q;
  logic             keep_p1_q;
  logic             start_hi_q;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] p1_cnt, p2_cnt;

  // named internal events
  logic ev_accept, ev_ru_hi, ev_rd_done, in_run, in_rd;

  msadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_async),
    .d_sync  (cmp_sync)
  );

  assign in_run     = (st_q == ST_RUN);
  assign in_rd      = (st_q == ST_RD_RUN);
  assign ev_accept  = (st_q == ST_IDLE) && cmd_valid;
  assign ev_ru_hi   = in_run && first_clk && cmp_sync;
  assign ev_rd_done = in_rd && (cmp_sync != start_hi_q);

  msadc_ru_timer #(.CNT_W(CNT_W), .CYC_CLKS(CYC_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .load_val  (cmd_cycles),
    .advance   (in_run),
    .first_clk (first_clk),
    .cyc_end   (cyc_end),
    .last_cyc  (last_cyc),
    .empty     (ru_empty)
  );

  msadc_rd_ctr #(.CNT_W(CNT_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_q == ST_RD_ARM),
    .inc_p1 (in_rd && !ev_rd_done && start_hi_q),
    .inc_p2 (in_rd && !ev_rd_done && !start_hi_q),
    .p1_cnt (p1_cnt),
    .p2_cnt (p2_cnt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid)      st_d = ST_REQ1;
        else if (!cmp_sync) st_d = ST_PUSH;
      end
      ST_PUSH:    if (push_q) st_d = ST_IDLE;
      ST_REQ1:    st_d = ST_WAIT1;
      ST_WAIT1:   if (aux_done) st_d = ru_empty ? ST_EMIT_HI : ST_RUN;
      ST_RUN:     if (last_cyc) st_d = ST_EMIT_HI;
      ST_EMIT_HI: if (rs_ready) st_d = ST_RD_ARM;
      ST_RD_ARM:  st_d = ST_RD_RUN;
      ST_RD_RUN:  if (ev_rd_done) st_d = ST_EMIT_P1;
      ST_EMIT_P1: if (rs_ready) st_d = ST_EMIT_P2;
      ST_EMIT_P2: if (rs_ready) st_d = ST_REQ2;
      ST_REQ2:    st_d = ST_WAIT2;
      ST_WAIT2:   if (aux_done) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      push_q     <= 1'b0;
      keep_p1_q  <= 1'b0;
      start_hi_q <= 1'b0;
      hi_q       <= '0;
    end else begin
      st_q <= st_d;
      // second of the two push clocks is flagged by push_q
      push_q <= (st_q == ST_PUSH) && !push_q;
      if (ev_accept) hi_q <= ALL_ONES;
      else if (ev_ru_hi) hi_q <= hi_q - 1'b1;
      if (in_run && first_clk) keep_p1_q <= cmp_sync;
      if (st_q == ST_RD_ARM) start_hi_q <= cmp_sync;
    end
  end

  always_comb begin
    sw_sel    = SW_OFF;
    integ_en  = 1'b0;
    aux_req   = 1'b0;
    cmd_ready = 1'b0;
    rs_valid  = 1'b0;
    rs_data   = '0;
    rs_kind   = KIND_HI;
    unique case (st_q)
      ST_IDLE: begin
        sw_sel    = SW_P1;
        cmd_ready = 1'b1;
      end
      ST_PUSH: sw_sel = SW_P2;
      ST_REQ1, ST_REQ2: aux_req = 1'b1;
      ST_RUN: begin
        sw_sel   = runup_sel(first_clk, keep_p1_q);
        integ_en = 1'b1;
      end
      ST_EMIT_HI: begin
        rs_valid = 1'b1;
        rs_data  = hi_q;
        rs_kind  = KIND_HI;
      end
      ST_RD_RUN: sw_sel = rundown_sel(start_hi_q);
      ST_EMIT_P1: begin
        rs_valid = 1'b1;
        rs_data  = p1_cnt;
        rs_kind  = KIND_P1;
      end
      ST_EMIT_P2: begin
        rs_valid = 1'b1;
        rs_data  = p2_cnt;
        rs_kind  = KIND_P2;
      end
      default: ;
    endcase
  end

  logic unused_ok;
  assign unused_ok = cyc_end;

endmodule

// File: rtl/msadc_seq_chk.sv
module msadc_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       sw_sel,
  input logic             integ_en,
  input logic             aux_req,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic [CNT_W-1:0] rs_data,
  input logic [1:0]       rs_kind,
  input logic             ev_accept,
  input logic             ev_rd_done,
  input logic             cmp_sync
);

  // R11
  sw_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel != 2'b11);

  // R3
  integ_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    integ_en |-> (!aux_req && !rs_valid && !cmd_ready && sw_sel != 2'b00));

  // R8
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data) && $stable(rs_kind)));

  // R2
  aux_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_req |=> !aux_req);

  // R2
  accept_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (sw_sel == 2'b00 && aux_req && !cmd_ready));

  // R7
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_done |=> (rs_valid && rs_kind == 2'd1 && sw_sel == 2'b00));

  // R9
  dither_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid && !cmp_sync) |=> (sw_sel == 2'b10 && !cmd_ready));

endmodule

bind msadc_seq msadc_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .sw_sel     (sw_sel),
  .integ_en   (integ_en),
  .aux_req    (aux_req),
  .rs_valid   (rs_valid),
  .rs_ready   (rs_ready),
  .rs_data    (rs_data),
  .rs_kind    (rs_kind),
  .ev_accept  (ev_accept),
  .ev_rd_done (ev_rd_done),
  .cmp_sync   (cmp_sync)
);

// File: tb/msadc_seq_tb.sv
`timescale 1ns/1ps
module msadc_seq_tb;

  localparam int CNT_W = 16;
  localparam int CYC   = 6;
  localparam int SYNC  = 2;
  localparam int MASK  = (1 << CNT_W) - 1;
  localparam int WDOG  = 150000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [CNT_W-1:0] cmd_cycles = '0;
  logic             cmp_async = 1'b1;
  logic [1:0]       sw_sel;
  logic             integ_en;
  logic             aux_req;
  logic             aux_done = 1'b0;
  logic             rs_valid;
  logic             rs_ready = 1'b1;
  logic [CNT_W-1:0] rs_data;
  logic [1:0]       rs_kind;

  always #4 clk = ~clk;

  msadc_seq #(.CNT_W(CNT_W), .CYC_CLKS(CYC), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cycles(cmd_cycles), .cmp_async(cmp_async), .sw_sel(sw_sel),
    .integ_en(integ_en), .aux_req(aux_req), .aux_done(aux_done),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data), .rs_kind(rs_kind)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  // modes: 0 idle, 1 push, 2 req1, 3 wait1, 4 runup, 5 word hi,
  // 6 rundown arm, 7 rundown, 8 word p1, 9 word p2, 10 req2, 11 wait2
  int m_mode = 0, m_k = 0, m_left = 0, m_hi = 0, m_p1 = 0, m_p2 = 0;
  bit m_keep = 0, m_start = 0;
  bit m_q[$];

  initial for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_k = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);
    end else begin
      bit cs;
      cs = m_q[SYNC-1];
      case (m_mode)
        0: if (cmd_valid) begin m_left = int'(cmd_cycles); m_hi = MASK; m_mode = 2; end
           else if (!cs) begin m_mode = 1; m_k = 0; end
        1: if (m_k == 1) m_mode = 0; else m_k++;
        2: m_mode = 3;
        3: if (aux_done) begin m_mode = (m_left == 0) ? 5 : 4; m_k = 0; end
        4: begin
             if (m_k == 0) begin m_keep = cs; if (cs) m_hi--; end
             if (m_k == CYC - 1) begin
               m_k = 0; m_left--;
               if (m_left == 0) m_mode = 5;
             end else m_k++;
           end
        5: if (rs_ready) m_mode = 6;
        6: begin m_start = cs; m_p1 = 0; m_p2 = 0; m_mode = 7; end
        7: if (cs != m_start) m_mode = 8;
           else if (m_start) m_p1++; else m_p2++;
        8: if (rs_ready) m_mode = 9;
        9: if (rs_ready) m_mode = 10;
        10: m_mode = 11;
        11: if (aux_done) m_mode = 0;
        default: m_mode = 0;
      endcase
      m_q.push_front(cmp_async);
      void'(m_q.pop_back());
    end
  end

  function automatic int exp_sw();
    case (m_mode)
      0: return 1;
      1: return 2;
      4: return (m_k == 0 || m_keep) ? 1 : 2;
      7: return m_start ? 1 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic string sw_tag();
    case (m_mode)
      0, 1: return "R9";
      4: return "R4";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(sw_tag(), int'(sw_sel), exp_sw());
      chk("R11 sw_sel legal", int'(sw_sel == 2'b11), 0);
      chk("R3 integ_en", int'(integ_en), int'(m_mode == 4));
      chk("R2 aux_req", int'(aux_req), int'(m_mode == 2 || m_mode == 10));
      chk("R9 cmd_ready", int'(cmd_ready), int'(m_mode == 0));
      chk("R8 rs_valid", int'(rs_valid), int'(m_mode == 5 || m_mode == 8 || m_mode == 9));
      if (m_mode == 5) begin
        chk("R5 hi word", int'(rs_data), m_hi);
        chk("R7 kind", int'(rs_kind), 0);
      end
      if (m_mode == 8) begin
        chk("R6 p1 word", int'(rs_data), m_p1);
        chk("R7 kind", int'(rs_kind), 1);
      end
      if (m_mode == 9) begin
        chk("R6 p2 word", int'(rs_data), m_p2);
        chk("R7 kind", int'(rs_kind), 2);
      end
    end
  end

  // ---------------- environment ----------------
  bit use_integ = 0;
  bit ready_all = 1;
  bit spur_en = 0;
  int acc = 0;
  int aux_delay = 2;
  int aux_cnt = 0;

  always @(negedge clk) begin
    if (use_integ) begin
      acc += (sw_sel == 2'b01) ? -8 : (sw_sel == 2'b10) ? 8 : 0;
      acc += integ_en ? 3 : 0;
      cmp_async <= (acc > 0);
    end
    aux_done <= 1'b0;
    if (aux_req) aux_cnt = aux_delay;
    else if (aux_cnt > 0) begin
      aux_cnt--;
      if (aux_cnt == 0) aux_done <= 1'b1;
    end else if (spur_en && (cyc % 7 == 3)) aux_done <= 1'b1;
    rs_ready <= ready_all ? 1'b1 : (cyc % 3 == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WDOG && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send_cmd(input int n);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_cycles = CNT_W'(n);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_mode != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R1: reset state observed while reset is held
    repeat (3) @(negedge clk);
    chk("R1 sw_sel", int'(sw_sel), 1);
    chk("R1 integ_en", int'(integ_en), 0);
    chk("R1 aux_req", int'(aux_req), 0);
    chk("R1 rs_valid", int'(rs_valid), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);

    // R10: comparator fall reaches the switches in the third clock
    cmp_async = 1'b0;
    @(negedge clk); chk("R10 sync +1", int'(sw_sel), 1);
    @(negedge clk); chk("R10 sync +2", int'(sw_sel), 1);
    @(negedge clk); chk("R10 sync +3", int'(sw_sel), 2);
    @(negedge clk); chk("R9 push second clock", int'(sw_sel), 2);
    @(negedge clk); chk("R9 back to probe", int'(sw_sel), 1);

    // R9 collision: command raised while dithering on a low comparator
    repeat (2) @(negedge clk);
    send_cmd(2);
    acc = -5;
    use_integ = 1;
    wait_idle();

    // regular conversions, R3 R4 R5 R6 R7
    send_cmd(3);
    wait_idle();
    send_cmd(0);   // R5: run-up skipped
    wait_idle();
    ready_all = 0; // R8: stalled result stream
    aux_delay = 5;
    send_cmd(5);
    wait_idle();
    spur_en = 1;   // R2: stray acknowledges
    aux_delay = 9;
    send_cmd(4);
    wait_idle();
    spur_en = 0;
    ready_all = 1;
    aux_delay = 1;
    send_cmd(1);
    wait_idle();
    send_cmd(9);
    wait_idle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule